// File: doc/BRIEF.md
# Operand-Collecting Reservation Station Pool

This block is a small pool of reservation stations that sits in front of a single functional unit. An instruction enters through a valid/ready issue port. It carries an operation code and two source operands. Each operand is a pair: a data word plus a producer tag. A tag of zero says the data word is already the operand. A nonzero tag names the unit whose future result will supply it. Each accepted instruction lands in the lowest-numbered free entry, and that entry takes a fixed nonzero name of its own.

Busy entries watch a shared result broadcast bus. Whenever the bus carries a tag that matches a waiting operand, the entry copies the bus value and marks that operand as present. The two operands may be filled in different cycles. An entry with both operands present and not yet sent is ready. The ready entries compete for one valid/ready dispatch port in fixed order, lowest number first. The dispatch port carries the entry's own name, which the functional unit later broadcasts with its result. The entry is freed when the bus carries that name.

Back-pressure rules: an issue beat is accepted on a clock edge where `iss_valid` and `iss_ready` are both high, and `iss_ready` is low exactly when every entry is busy. A dispatch beat completes on an edge where `dsp_valid` and `dsp_ready` are both high. Once `dsp_valid` is raised, it stays high and the offered beat stays unchanged until it is taken.

Top module: `rs_pool`

## Requirements
- R1: After reset every entry is free: `pool_full` is 0, `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An accepted issue fills the lowest-numbered free entry, and entry i (counting from 0) is named TAG_BASE+i, so with the defaults the entries are named 1, 2 and 3. A freed entry is the one refilled next.
- R3: While all entries are busy, `pool_full` is 1 and `iss_ready` is 0, and an `iss_valid` beat in that state creates no entry.
- R4: An operand with a nonzero tag is treated as missing, and an entry with any missing operand is never offered for dispatch.
- R5: A busy entry whose missing operand's tag equals `bc_tag` while `bc_valid` is high captures `bc_value` into that operand. Operands filled in different cycles are both kept. The entry can be offered from the cycle after its last operand arrives.
- R6: When an issued operand's tag matches a broadcast in the same cycle as the issue, the operand is stored as the broadcast value.
- R7: When several entries are ready and no offer is pending, the lowest-numbered entry is offered first.
- R8: While `dsp_valid` is high and `dsp_ready` is low, the next cycle keeps `dsp_valid` high, and `dsp_tag`, `dsp_op`, `dsp_vj` and `dsp_vk` stay unchanged, even if a lower-numbered entry becomes ready.
- R9: Each entry is dispatched once per issue. Its entry stays busy until the bus carries its own name, and it is free in the next cycle.
- R10: A broadcast whose tag matches no waiting operand and no entry name changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue beat present |
| iss_ready | output | 1 | Pool can accept an issue beat |
| pool_full | output | 1 | All entries busy (structural stall) |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_vj | input | DATA_W | First operand value |
| iss_qj | input | TAG_W | First operand producer tag, 0 = value present |
| iss_vk | input | DATA_W | Second operand value |
| iss_qk | input | TAG_W | Second operand producer tag, 0 = value present |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Name of the producer of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | An entry is offered to the functional unit |
| dsp_ready | input | 1 | Functional unit accepts the offer |
| dsp_op | output | OP_W | Operation code of the offered entry |
| dsp_vj | output | DATA_W | First operand of the offered entry |
| dsp_vk | output | DATA_W | Second operand of the offered entry |
| dsp_tag | output | TAG_W | Name of the offered entry |

## Verification
Suppose a tag comparison is wrong or an operand is captured on the wrong edge. Then a dispatch beat carries a stale value, or it appears a cycle early or late. That shows at the dispatch port in the cycle after the deciding broadcast. If busy bookkeeping goes wrong, it shows as a wrong `pool_full`, a second dispatch of the same name, or a refill going to the wrong entry name. These appear within one or two cycles of the release broadcast or the extra issue beat. A wrong ordering or hold decision shows as dispatch names that come out of the scoreboard's order.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_ENTRIES  = 3;
  localparam int RS_DATA_W   = 32;
  localparam int RS_OP_W     = 4;
  localparam int RS_TAG_W    = 3;
  localparam int RS_TAG_BASE = 1;
endpackage

// File: rtl/rs_pick.sv
// Fixed-order picker: grants the lowest-indexed request.
module rs_pick #(
  parameter int N = rs_pkg::RS_ENTRIES
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rs_entry.sv
// One station: holds an opcode and two value/tag operand pairs and snoops the bus.
module rs_entry #(
  parameter int DATA_W = rs_pkg::RS_DATA_W,
  parameter int OP_W   = rs_pkg::RS_OP_W,
  parameter int TAG_W  = rs_pkg::RS_TAG_W,
  parameter logic [TAG_W-1:0] OWN_TAG = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_vj,
  input  logic [TAG_W-1:0]  in_qj,
  input  logic [DATA_W-1:0] in_vk,
  input  logic [TAG_W-1:0]  in_qk,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  input  logic              send,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  logic [TAG_W-1:0] qj, qk;
  logic             sent;

  // Tag hits on the bus for the issue-time operands and the stored ones.
  logic hit_in_j, hit_in_k, hit_j, hit_k, hit_own;
  assign hit_in_j = bc_valid && (in_qj != '0) && (bc_tag == in_qj);
  assign hit_in_k = bc_valid && (in_qk != '0) && (bc_tag == in_qk);
  assign hit_j    = busy && bc_valid && (qj != '0) && (bc_tag == qj);
  assign hit_k    = busy && bc_valid && (qk != '0) && (bc_tag == qk);
  assign hit_own  = busy && bc_valid && (bc_tag == OWN_TAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sent <= 1'b0;
      op   <= '0;
      vj   <= '0;
      vk   <= '0;
      qj   <= '0;
      qk   <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      sent <= 1'b0;
      op   <= in_op;
      vj   <= hit_in_j ? bc_value : in_vj;
      qj   <= hit_in_j ? '0 : in_qj;
      vk   <= hit_in_k ? bc_value : in_vk;
      qk   <= hit_in_k ? '0 : in_qk;
    end else begin
      if (hit_own) busy <= 1'b0;
      if (send)    sent <= 1'b1;
      if (hit_j) begin
        vj <= bc_value;
        qj <= '0;
      end
      if (hit_k) begin
        vk <= bc_value;
        qk <= '0;
      end
    end
  end

  assign ready = busy && !sent && (qj == '0) && (qk == '0);
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N        = rs_pkg::RS_ENTRIES,
  parameter int DATA_W   = rs_pkg::RS_DATA_W,
  parameter int OP_W     = rs_pkg::RS_OP_W,
  parameter int TAG_W    = rs_pkg::RS_TAG_W,
  parameter int TAG_BASE = rs_pkg::RS_TAG_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  output logic              pool_full,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_vj,
  output logic [DATA_W-1:0] dsp_vk,
  output logic [TAG_W-1:0]  dsp_tag
);
  logic [N-1:0]      busy, rdy, alloc, send;
  logic [N-1:0]      free_gnt, rdy_gnt, dsp_gnt, hold_gnt;
  logic              free_any, rdy_any, hold_vld;
  logic [OP_W-1:0]   ent_op [N];
  logic [DATA_W-1:0] ent_vj [N];
  logic [DATA_W-1:0] ent_vk [N];

  rs_pick #(.N(N)) u_free_pick (.req(~busy), .gnt(free_gnt), .any(free_any));
  rs_pick #(.N(N)) u_rdy_pick  (.req(rdy),   .gnt(rdy_gnt),  .any(rdy_any));

  assign iss_ready = free_any;
  assign pool_full = ~free_any;

  // A pending offer is locked so the dispatch beat stays stable under back-pressure.
  assign dsp_gnt   = hold_vld ? hold_gnt : rdy_gnt;
  assign dsp_valid = hold_vld | rdy_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_gnt <= '0;
    end else begin
      hold_vld <= dsp_valid && !dsp_ready;
      hold_gnt <= dsp_gnt;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign alloc[g] = iss_valid && free_gnt[g];
    assign send[g]  = dsp_valid && dsp_ready && dsp_gnt[g];

    rs_entry #(
      .DATA_W (DATA_W),
      .OP_W   (OP_W),
      .TAG_W  (TAG_W),
      .OWN_TAG(TAG_W'(TAG_BASE + g))
    ) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc   (alloc[g]),
      .in_op   (iss_op),
      .in_vj   (iss_vj),
      .in_qj   (iss_qj),
      .in_vk   (iss_vk),
      .in_qk   (iss_qk),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .bc_value(bc_value),
      .send    (send[g]),
      .busy    (busy[g]),
      .ready   (rdy[g]),
      .op      (ent_op[g]),
      .vj      (ent_vj[g]),
      .vk      (ent_vk[g])
    );
  end

  // One-hot OR mux of the granted entry onto the dispatch port.
  always_comb begin
    dsp_op  = '0;
    dsp_vj  = '0;
    dsp_vk  = '0;
    dsp_tag = '0;
    for (int i = 0; i < N; i++) begin
      dsp_op  |= {OP_W{dsp_gnt[i]}}   & ent_op[i];
      dsp_vj  |= {DATA_W{dsp_gnt[i]}} & ent_vj[i];
      dsp_vk  |= {DATA_W{dsp_gnt[i]}} & ent_vk[i];
      dsp_tag |= {TAG_W{dsp_gnt[i]}}  & TAG_W'(TAG_BASE + i);
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N        = 3,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  parameter int TAG_W    = 3,
  parameter int TAG_BASE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      busy_vec,
  input logic              pool_full,
  input logic              bc_valid,
  input logic [TAG_W-1:0]  bc_tag,
  input logic              dsp_valid,
  input logic              dsp_ready,
  input logic [OP_W-1:0]   dsp_op,
  input logic [DATA_W-1:0] dsp_vj,
  input logic [DATA_W-1:0] dsp_vk,
  input logic [TAG_W-1:0]  dsp_tag
);
  logic [TAG_W-1:0] rel;
  logic [N-1:0]     shifted;
  assign rel     = dsp_tag - TAG_W'(TAG_BASE);
  assign shifted = busy_vec >> rel;

  // R3: a full pool stays full until some broadcast arrives
  a_r3_full_until_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full && !bc_valid |=> pool_full);

  // R8: an unaccepted offer is held unchanged
  a_r8_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && !dsp_ready |=> dsp_valid && $stable(dsp_tag) && $stable(dsp_op)
                                && $stable(dsp_vj) && $stable(dsp_vk));

  // R2: the offered name belongs to a busy entry of this pool
  a_r2_offer_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (int'(rel) < N) && shifted[0]);

  // R2: at most one entry is filled per cycle
  a_r2_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(busy_vec) <= $past($countones(busy_vec)) + 1);

  for (genvar g = 0; g < N; g++) begin : g_rel
    // R9: own-name broadcast frees the entry next cycle
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      busy_vec[g] && bc_valid && (bc_tag == TAG_W'(TAG_BASE + g)) |=> !busy_vec[g]);
  end
endmodule

bind rs_pool rs_pool_chk #(
  .N(N), .DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_vec(busy), .pool_full(pool_full),
  .bc_valid(bc_valid), .bc_tag(bc_tag), .dsp_valid(dsp_valid), .dsp_ready(dsp_ready),
  .dsp_op(dsp_op), .dsp_vj(dsp_vj), .dsp_vk(dsp_vk), .dsp_tag(dsp_tag)
);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0, iss_ready, pool_full;
  logic [3:0]  iss_op = '0;
  logic [31:0] iss_vj = '0, iss_vk = '0;
  logic [2:0]  iss_qj = '0, iss_qk = '0;
  logic        bc_valid = 1'b0;
  logic [2:0]  bc_tag = '0;
  logic [31:0] bc_value = '0;
  logic        dsp_valid, dsp_ready = 1'b0;
  logic [3:0]  dsp_op;
  logic [31:0] dsp_vj, dsp_vk;
  logic [2:0]  dsp_tag;

  int compared = 0, mismatched = 0;

  typedef struct {
    logic [2:0]  tag;
    logic [3:0]  op;
    logic [31:0] vj, vk;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  rs_pool dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .pool_full(pool_full), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
    .iss_vk(iss_vk), .iss_qk(iss_qk), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_value(bc_value), .dsp_valid(dsp_valid), .dsp_ready(dsp_ready),
    .dsp_op(dsp_op), .dsp_vj(dsp_vj), .dsp_vk(dsp_vk), .dsp_tag(dsp_tag)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_d(input logic [2:0] t, input logic [3:0] o,
                          input logic [31:0] j, input logic [31:0] k);
    exp_t e;
    e.tag = t; e.op = o; e.vj = j; e.vk = k;
    sb.push_back(e);
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] j, input logic [2:0] qj,
                       input logic [31:0] k, input logic [2:0] qk);
    iss_valid = 1'b1; iss_op = o; iss_vj = j; iss_qj = qj; iss_vk = k; iss_qk = qk;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [31:0] v);
    bc_valid = 1'b1; bc_tag = t; bc_value = v;
    tick();
    bc_valid = 1'b0;
  endtask

  task automatic free_all();
    bcast(3'd1, 32'd0);
    bcast(3'd2, 32'd0);
    bcast(3'd3, 32'd0);
  endtask

  // Monitor: pops the scoreboard on every completed dispatch beat.
  always @(negedge clk) begin
    if (rst_n && dsp_valid && dsp_ready) begin
      compared++;
      if (sb.size() == 0) begin
        mismatched++;
        $display("FAIL R9: unexpected dispatch tag %0d", dsp_tag);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (dsp_tag != e.tag || dsp_op != e.op || dsp_vj != e.vj || dsp_vk != e.vk) begin
          mismatched++;
          $display("FAIL R2/R5/R7: got tag %0d op %0d vj %0d vk %0d expected tag %0d op %0d vj %0d vk %0d",
                   dsp_tag, dsp_op, dsp_vj, dsp_vk, e.tag, e.op, e.vj, e.vk);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pool_full", pool_full, 0);
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 dsp_valid", dsp_valid, 0);
    tick();

    // R2/R3/R8: fill with ready ops under back-pressure
    issue(4'd1, 32'd10, 3'd0, 32'd20, 3'd0);
    issue(4'd2, 32'd30, 3'd0, 32'd40, 3'd0);
    issue(4'd3, 32'd50, 3'd0, 32'd60, 3'd0);
    @(negedge clk);
    chk("R3 pool_full", pool_full, 1);
    chk("R3 iss_ready", iss_ready, 0);
    chk("R8 held tag", dsp_tag, 1);
    tick();
    issue(4'd9, 32'd99, 3'd0, 32'd99, 3'd0);  // R3: ignored while full
    issue(4'd9, 32'd98, 3'd0, 32'd98, 3'd0);
    expect_d(3'd1, 4'd1, 32'd10, 32'd20);
    expect_d(3'd2, 4'd2, 32'd30, 32'd40);
    expect_d(3'd3, 4'd3, 32'd50, 32'd60);
    dsp_ready = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    chk("R9 no second dispatch", dsp_valid, 0);
    chk("R9 still busy", pool_full, 1);
    tick();
    bcast(3'd2, 32'd0);
    @(negedge clk);
    chk("R9 freed", pool_full, 0);
    tick();
    expect_d(3'd2, 4'd5, 32'd7, 32'd8);       // R2: refill goes to freed entry
    issue(4'd5, 32'd7, 3'd0, 32'd8, 3'd0);
    tick();
    free_all();
    @(negedge clk);
    chk("R9 all free", pool_full, 0);
    chk("R3 ignored issue left no entry", dsp_valid, 0);
    tick();

    // R4/R5/R10: operands arrive in different cycles
    issue(4'd6, 32'd0, 3'd5, 32'd0, 3'd6);
    @(negedge clk);
    chk("R4 waiting", dsp_valid, 0);
    tick();
    bcast(3'd7, 32'd99);
    @(negedge clk);
    chk("R10 unrelated bcast", dsp_valid, 0);
    tick();
    bcast(3'd5, 32'd111);
    @(negedge clk);
    chk("R5 one operand", dsp_valid, 0);
    tick();
    expect_d(3'd1, 4'd6, 32'd111, 32'd222);
    bcast(3'd6, 32'd222);
    @(negedge clk);
    chk("R5 offered after fill", dsp_valid, 1);
    tick();
    @(negedge clk);
    chk("R9 once", dsp_valid, 0);
    tick();
    free_all();

    // R6: capture at issue from same-cycle broadcast
    expect_d(3'd1, 4'd7, 32'd77, 32'd8);
    iss_valid = 1'b1; iss_op = 4'd7; iss_vj = 32'd0; iss_qj = 3'd5; iss_vk = 32'd8; iss_qk = 3'd0;
    bc_valid = 1'b1; bc_tag = 3'd5; bc_value = 32'd77;
    tick();
    iss_valid = 1'b0; bc_valid = 1'b0;
    @(negedge clk);
    chk("R6 ready next cycle", dsp_valid, 1);
    tick();
    tick();
    free_all();

    // R7: three become ready together
    issue(4'd1, 32'd0, 3'd5, 32'd1, 3'd0);
    issue(4'd2, 32'd0, 3'd5, 32'd2, 3'd0);
    issue(4'd3, 32'd0, 3'd5, 32'd3, 3'd0);
    expect_d(3'd1, 4'd1, 32'd55, 32'd1);
    expect_d(3'd2, 4'd2, 32'd55, 32'd2);
    expect_d(3'd3, 4'd3, 32'd55, 32'd3);
    bcast(3'd5, 32'd55);
    repeat (4) tick();
    free_all();

    // R8: a lower entry becoming ready does not displace a pending offer
    dsp_ready = 1'b0;
    issue(4'd4, 32'd0, 3'd5, 32'd4, 3'd0);
    issue(4'd8, 32'd12, 3'd0, 32'd13, 3'd0);
    @(negedge clk);
    chk("R8 offer entry 2", dsp_tag, 2);
    tick();
    bcast(3'd5, 32'd66);
    @(negedge clk);
    chk("R8 offer kept", dsp_tag, 2);
    chk("R8 valid kept", dsp_valid, 1);
    tick();
    expect_d(3'd2, 4'd8, 32'd12, 32'd13);
    expect_d(3'd1, 4'd4, 32'd66, 32'd4);
    dsp_ready = 1'b1;
    repeat (3) tick();
    free_all();

    chk("R7 scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule